// File: doc/BRIEF.md
# Shadowed IR Mode Configuration Registers

This block is the register file that sets up an infrared modem. Software programs a configuration word and a pending physical-layer word through a 16-bit register port. The mode selection (slow, medium or fast encoding, plus the 16-bit CRC choice) and the physical-layer word are shadowed. Software may rewrite them at any time, but the modem only sees new values when the enable bit in the enable/status word goes from 0 to 1. The same write that raises the enable bit also commits the pending values.

At that commit the block counts the selected encoding modes. If the count is not exactly one, it latches a configuration error and keeps every mode-on output low. The transmit enable, receive enable, loopback and the other plain control bits are not shadowed and drive the modem directly. Receive enable is interlocked so that it is suppressed while transmitting, unless loopback is on. Outside the register port, the block presents decoded outputs for the modem logic, which lies outside this block.

Top module: `ir_mode_cfg_regs`

## Requirements
- R1: After reset (active-low `rst_n`) all four register addresses read 0 and every decoded output is 0.
- R2: Address 0 holds the configuration word. Its bit positions are: loopback 14, transmit enable 12, receive enable 11, bus-master enable 10, receive-any 9, CRC16 select 7, fast mode 6, medium mode 5, slow mode 4, slow-decode filter 3, filter test 2, transmit polarity invert 1, receive polarity invert 0. Bits 15, 13 and 8 are not stored and read 0.
- R3: Address 1 holds the pending physical word: baud divisor [15:10], pulse width [9:5], preamble [4:0]. All 16 bits read back. Writes to it or to the mode bits of address 0 do not change `cur_*`, the mode outputs or address 2 until a commit.
- R4: A write to address 3 with bit 15 set while enable is 0 is a commit. On the clock edge that takes the write, address 2 and `cur_baud`/`cur_width`/`cur_preamble` take the pending word, and the mode and CRC16 bits are applied. Writing bit 15 = 1 while already enabled does not commit. Writing bit 15 = 0 clears enable and keeps the applied values.
- R5: Address 2 is read-only, and writes to it are ignored.
- R6: Address 3 reads: 15 enable, 14 config error, 13 fast on, 12 medium on, 11 slow on, 10 transmit status, 9 receive status, 8 CRC16 on. Bits 7:0 read 0. Writes affect only bit 15.
- R7: Transmit status (bit 10 and `tx_en`) follows the live transmit-enable bit of address 0 without a commit.
- R8: Receive status (bit 9 and `rx_en`) equals receive enable AND (NOT transmit enable OR loopback), from the live configuration word.
- R9: At a commit, the config error is set when the number of selected modes among slow/medium/fast is not exactly one, and cleared otherwise. While it is set, no mode-on bit is asserted. It holds until the next commit.
- R10: Mode-on and CRC16-on bits are asserted only while enable is 1, and they reflect the applied (committed) values.
- R11: Loopback, bus-master, receive-any, filter, filter-test and both polarity outputs follow the live configuration word directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| phy_en | output | 1 | Enable bit |
| mode_sir | output | 1 | Slow encoding mode on |
| mode_mir | output | 1 | Medium encoding mode on |
| mode_fir | output | 1 | Fast encoding mode on |
| crc16_sel | output | 1 | 16-bit CRC applied and enabled |
| cfg_err | output | 1 | Configuration error latched at commit |
| tx_en | output | 1 | Transmit enable status |
| rx_en | output | 1 | Interlocked receive enable status |
| loop_en | output | 1 | Loopback |
| master_en | output | 1 | Bus-master enable |
| rx_any | output | 1 | Accept any received packet |
| sir_filt | output | 1 | Slow-mode receive unwrapping filter |
| sir_filt_test | output | 1 | Allow filter outside slow mode |
| tx_invert | output | 1 | Invert transmit polarity |
| rx_invert | output | 1 | Invert receive polarity |
| cur_baud | output | BAUD_W | Applied baud divisor |
| cur_width | output | WIDTH_W | Applied pulse width |
| cur_preamble | output | PRE_W | Applied preamble count |

## Verification
The assertions assume a single-port register interface: each cycle carries at most one write, so the pending physical word can never change in the same cycle as a commit. The commit check compares the applied word with the value held one cycle earlier. The bench drives the port on falling edges, issues one write per task step, and never writes two addresses at once. It also reads with the default combinational read path, so register contents are visible one cycle after the write edge.

// File: rtl/ir_mcfg_pkg.sv
package ir_mcfg_pkg;

   // register addresses
   localparam int ADR_CFG  = 0;
   localparam int ADR_NPHY = 1;
   localparam int ADR_CPHY = 2;
   localparam int ADR_STAT = 3;

   // configuration word bit positions
   localparam int CB_RXINV  = 0;
   localparam int CB_TXINV  = 1;
   localparam int CB_FTEST  = 2;
   localparam int CB_FILT   = 3;
   localparam int CB_SIR    = 4;
   localparam int CB_MIR    = 5;
   localparam int CB_FIR    = 6;
   localparam int CB_CRC16  = 7;
   localparam int CB_RXANY  = 9;
   localparam int CB_MASTER = 10;
   localparam int CB_RXEN   = 11;
   localparam int CB_TXEN   = 12;
   localparam int CB_LOOP   = 14;

   // enable/status word bit positions
   localparam int SB_CRC16 = 8;
   localparam int SB_RX    = 9;
   localparam int SB_TX    = 10;
   localparam int SB_SIR   = 11;
   localparam int SB_MIR   = 12;
   localparam int SB_FIR   = 13;
   localparam int SB_ERR   = 14;
   localparam int SB_EN    = 15;

   typedef struct packed {
      logic crc16;
      logic fir;
      logic mir;
      logic sir;
   } mode_sel_t;

endpackage

// File: rtl/ir_mcfg_store.sv
module ir_mcfg_store #(
   parameter int          DATA_W    = 16,
   parameter logic [15:0] CFG_WMASK = 16'h5EFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cfg,
   input  logic              wr_nphy,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cfg_q,
   output logic [DATA_W-1:0] nphy_q
);
   localparam logic [DATA_W-1:0] WMASK = DATA_W'(CFG_WMASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         nphy_q <= '0;
      end else begin
         if (wr_cfg)  cfg_q  <= wdata & WMASK;
         if (wr_nphy) nphy_q <= wdata;
      end
   end

   // R2: bits outside the stored mask never become set
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q & ~WMASK) == '0);

endmodule

// File: rtl/ir_mcfg_commit.sv
module ir_mcfg_commit
   import ir_mcfg_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr,
   input  logic              en_wbit,
   input  mode_sel_t         mode_next,
   input  logic [DATA_W-1:0] nphy_q,
   output logic              en_q,
   output logic [DATA_W-1:0] cphy_q,
   output mode_sel_t         mode_q,
   output logic              err_q
);
   logic       en_rise;
   logic [1:0] mode_cnt;

   assign en_rise  = en_wr & en_wbit & ~en_q;
   assign mode_cnt = 2'(mode_next.sir) + 2'(mode_next.mir) + 2'(mode_next.fir);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         cphy_q <= '0;
         mode_q <= '0;
         err_q  <= 1'b0;
      end else begin
         if (en_wr) en_q <= en_wbit;
         if (en_rise) begin
            cphy_q <= nphy_q;
            mode_q <= mode_next;
            err_q  <= (mode_cnt != 2'd1);
         end
      end
   end

   // R4: at the enable edge the applied word equals the pending word
   a_r4_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> cphy_q == $past(nphy_q));

   // R3: while enable stays high the applied word does not move
   a_r3_hold_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && $past(en_q)) |-> $stable(cphy_q));

   // R4: disabling keeps the applied values
   a_r4_hold_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q) |-> ($stable(cphy_q) && $stable(mode_q)));

   // R9: error only changes at a commit
   a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(en_q) |-> $stable(err_q));

endmodule

// File: rtl/ir_mcfg_status.sv
module ir_mcfg_status
   import ir_mcfg_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_q,
   input  logic              err_q,
   input  mode_sel_t         mode_q,
   input  logic              live_tx,
   input  logic              live_rx,
   input  logic              live_loop,
   output logic              sir_on,
   output logic              mir_on,
   output logic              fir_on,
   output logic              crc16_on,
   output logic              tx_st,
   output logic              rx_st,
   output logic [DATA_W-1:0] stat_word
);
   logic mode_ok;

   assign mode_ok  = en_q & ~err_q;
   assign sir_on   = mode_ok & mode_q.sir;
   assign mir_on   = mode_ok & mode_q.mir;
   assign fir_on   = mode_ok & mode_q.fir;
   assign crc16_on = en_q & mode_q.crc16;
   assign tx_st    = live_tx;
   assign rx_st    = live_rx & (~live_tx | live_loop);

   always_comb begin
      stat_word           = '0;
      stat_word[SB_EN]    = en_q;
      stat_word[SB_ERR]   = err_q;
      stat_word[SB_FIR]   = fir_on;
      stat_word[SB_MIR]   = mir_on;
      stat_word[SB_SIR]   = sir_on;
      stat_word[SB_TX]    = tx_st;
      stat_word[SB_RX]    = rx_st;
      stat_word[SB_CRC16] = crc16_on;
   end

   // R8: receive never reported while transmitting without loopback
   a_r8_rx_interlock: assert property (@(posedge clk) disable iff (!rst_n)
      rx_st |-> (!live_tx || live_loop));

   // R9: error suppresses every mode-on bit
   a_r9_err_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !(sir_on || mir_on || fir_on));

   // R9: at most one mode on at a time
   a_r9_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sir_on, mir_on, fir_on}));

   // R10: modes only while enabled
   a_r10_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      (sir_on || mir_on || fir_on || crc16_on) |-> en_q);

endmodule

// File: rtl/ir_mode_cfg_regs.sv
module ir_mode_cfg_regs
   import ir_mcfg_pkg::*;
#(
   parameter int          DATA_W     = 16,
   parameter int          ADDR_W     = 2,
   parameter int          BAUD_W     = 6,
   parameter int          WIDTH_W    = 5,
   parameter int          PRE_W      = 5,
   parameter logic [15:0] CFG_WMASK  = 16'h5EFF,
   parameter logic [15:0] STAT_RMASK = 16'hFF00,
   parameter bit          READ_REG   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_we,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               phy_en,
   output logic               mode_sir,
   output logic               mode_mir,
   output logic               mode_fir,
   output logic               crc16_sel,
   output logic               cfg_err,
   output logic               tx_en,
   output logic               rx_en,
   output logic               loop_en,
   output logic               master_en,
   output logic               rx_any,
   output logic               sir_filt,
   output logic               sir_filt_test,
   output logic               tx_invert,
   output logic               rx_invert,
   output logic [BAUD_W-1:0]  cur_baud,
   output logic [WIDTH_W-1:0] cur_width,
   output logic [PRE_W-1:0]   cur_preamble
);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADR_CFG);
   localparam logic [ADDR_W-1:0] A_NPHY = ADDR_W'(ADR_NPHY);
   localparam logic [ADDR_W-1:0] A_CPHY = ADDR_W'(ADR_CPHY);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
   localparam int                W_LSB  = PRE_W;
   localparam int                B_LSB  = PRE_W + WIDTH_W;
   localparam logic [DATA_W-1:0] RMASK  = DATA_W'(STAT_RMASK);

   generate
      if (DATA_W != 16) begin : g_bad_data
         $error("DATA_W must be 16 for this bit map");
      end
      if (BAUD_W + WIDTH_W + PRE_W != DATA_W) begin : g_bad_split
         $error("physical word fields must fill DATA_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must reach four registers");
      end
   endgenerate

   logic              wr_cfg, wr_nphy, wr_stat;
   logic [DATA_W-1:0] cfg_q, nphy_q, cphy_q, stat_word, rd_mux;
   logic              en_q, err_q;
   mode_sel_t         mode_next, mode_q;
   logic              sir_on, mir_on, fir_on, crc16_on, tx_st, rx_st;

   assign wr_cfg  = reg_we && (reg_addr == A_CFG);
   assign wr_nphy = reg_we && (reg_addr == A_NPHY);
   assign wr_stat = reg_we && (reg_addr == A_STAT);

   ir_mcfg_store #(.DATA_W(DATA_W), .CFG_WMASK(CFG_WMASK)) store_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_cfg (wr_cfg),
      .wr_nphy(wr_nphy),
      .wdata  (reg_wdata),
      .cfg_q  (cfg_q),
      .nphy_q (nphy_q)
   );

   assign mode_next.crc16 = cfg_q[CB_CRC16];
   assign mode_next.fir   = cfg_q[CB_FIR];
   assign mode_next.mir   = cfg_q[CB_MIR];
   assign mode_next.sir   = cfg_q[CB_SIR];

   ir_mcfg_commit #(.DATA_W(DATA_W)) commit_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (wr_stat),
      .en_wbit  (reg_wdata[SB_EN]),
      .mode_next(mode_next),
      .nphy_q   (nphy_q),
      .en_q     (en_q),
      .cphy_q   (cphy_q),
      .mode_q   (mode_q),
      .err_q    (err_q)
   );

   ir_mcfg_status #(.DATA_W(DATA_W)) status_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_q     (en_q),
      .err_q    (err_q),
      .mode_q   (mode_q),
      .live_tx  (cfg_q[CB_TXEN]),
      .live_rx  (cfg_q[CB_RXEN]),
      .live_loop(cfg_q[CB_LOOP]),
      .sir_on   (sir_on),
      .mir_on   (mir_on),
      .fir_on   (fir_on),
      .crc16_on (crc16_on),
      .tx_st    (tx_st),
      .rx_st    (rx_st),
      .stat_word(stat_word)
   );

   always_comb begin
      unique case (reg_addr)
         A_CFG:   rd_mux = cfg_q;
         A_NPHY:  rd_mux = nphy_q;
         A_CPHY:  rd_mux = cphy_q;
         A_STAT:  rd_mux = stat_word & RMASK;
         default: rd_mux = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_rdata <= '0;
            else        reg_rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign reg_rdata = rd_mux;
         // R6: the low byte of the status word always reads zero
         a_r6_stat_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == A_STAT) |-> (reg_rdata[7:0] == 8'h00));
      end
   endgenerate

   assign phy_en        = en_q;
   assign mode_sir      = sir_on;
   assign mode_mir      = mir_on;
   assign mode_fir      = fir_on;
   assign crc16_sel     = crc16_on;
   assign cfg_err       = err_q;
   assign tx_en         = tx_st;
   assign rx_en         = rx_st;
   assign loop_en       = cfg_q[CB_LOOP];
   assign master_en     = cfg_q[CB_MASTER];
   assign rx_any        = cfg_q[CB_RXANY];
   assign sir_filt      = cfg_q[CB_FILT];
   assign sir_filt_test = cfg_q[CB_FTEST];
   assign tx_invert     = cfg_q[CB_TXINV];
   assign rx_invert     = cfg_q[CB_RXINV];
   assign cur_baud      = cphy_q[B_LSB +: BAUD_W];
   assign cur_width     = cphy_q[W_LSB +: WIDTH_W];
   assign cur_preamble  = cphy_q[0 +: PRE_W];

   // R5: a write to the read-only address leaves the applied word alone
   a_r5_cphy_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_CPHY && en_q) |=> $stable(cphy_q));

endmodule

// File: tb/ir_mode_cfg_regs_tb.sv
module ir_mode_cfg_regs_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        phy_en, mode_sir, mode_mir, mode_fir, crc16_sel, cfg_err;
   logic        tx_en, rx_en, loop_en, master_en, rx_any, sir_filt;
   logic        sir_filt_test, tx_invert, rx_invert;
   logic [5:0]  cur_baud;
   logic [4:0]  cur_width, cur_preamble;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ir_mode_cfg_regs dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phy_en(phy_en),
      .mode_sir(mode_sir), .mode_mir(mode_mir), .mode_fir(mode_fir),
      .crc16_sel(crc16_sel), .cfg_err(cfg_err), .tx_en(tx_en), .rx_en(rx_en),
      .loop_en(loop_en), .master_en(master_en), .rx_any(rx_any),
      .sir_filt(sir_filt), .sir_filt_test(sir_filt_test),
      .tx_invert(tx_invert), .rx_invert(rx_invert), .cur_baud(cur_baud),
      .cur_width(cur_width), .cur_preamble(cur_preamble)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic t_reset;
      logic [15:0] v;
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk("R1 reg after reset", v, 16'h0000);
      end
      chk("R1 outputs after reset",
          {phy_en, mode_sir, mode_mir, mode_fir, crc16_sel, cfg_err, tx_en, rx_en,
           loop_en, master_en, rx_any, sir_filt, sir_filt_test, tx_invert, rx_invert, 1'b0},
          16'h0000);
      chk("R1 current phy outputs", {cur_baud, cur_width, cur_preamble}, 16'h0000);
   endtask

   task automatic t_cfg_rw;
      logic [15:0] v;
      wr(2'd0, 16'hFFFF);
      rd(2'd0, v);
      chk("R2 reserved bits read zero", v, 16'h5EFF);
      wr(2'd0, 16'h0000);
      rd(2'd0, v);
      chk("R2 cleared", v, 16'h0000);
   endtask

   task automatic t_shadow_commit;
      logic [15:0] v;
      wr(2'd1, 16'hABCD);
      wr(2'd0, 16'h0090);
      rd(2'd1, v);
      chk("R3 pending readback", v, 16'hABCD);
      rd(2'd2, v);
      chk("R3 current not yet applied", v, 16'h0000);
      chk("R3 mode not yet applied", {15'd0, mode_sir}, 16'h0000);
      wr(2'd3, 16'h8000);
      rd(2'd2, v);
      chk("R4 current after commit", v, 16'hABCD);
      chk("R4 fields", {cur_baud, cur_width, cur_preamble}, {6'h2A, 5'h1E, 5'h0D});
      rd(2'd3, v);
      chk("R6 status slow+crc16", v, 16'h8900);
      wr(2'd1, 16'h1234);
      wr(2'd0, 16'h0020);
      rd(2'd2, v);
      chk("R3 current held while enabled", v, 16'hABCD);
      chk("R3 slow mode still applied", {15'd0, mode_sir}, 16'h0001);
      wr(2'd3, 16'hFFFF);
      rd(2'd2, v);
      chk("R4 no recommit when enabled", v, 16'hABCD);
      rd(2'd3, v);
      chk("R6 status writes ignored", v, 16'h8900);
   endtask

   task automatic t_cphy_ro;
      logic [15:0] v;
      wr(2'd2, 16'hFFFF);
      rd(2'd2, v);
      chk("R5 current phy read-only", v, 16'hABCD);
   endtask

   task automatic t_disable_recommit;
      logic [15:0] v;
      wr(2'd3, 16'h0000);
      rd(2'd3, v);
      chk("R10 modes off when disabled", v, 16'h0000);
      rd(2'd2, v);
      chk("R4 disable keeps applied", v, 16'hABCD);
      wr(2'd3, 16'h8000);
      rd(2'd2, v);
      chk("R4 second commit", v, 16'h1234);
      rd(2'd3, v);
      chk("R10 medium on from applied", v, 16'h9000);
   endtask

   task automatic t_txrx;
      logic [15:0] v;
      wr(2'd0, 16'h1820);
      rd(2'd3, v);
      chk("R7 R8 tx and rx, no loop", v, 16'h9400);
      chk("R8 rx_en blocked", {14'd0, tx_en, rx_en}, 16'h0002);
      wr(2'd0, 16'h0820);
      rd(2'd3, v);
      chk("R8 rx only", v, 16'h9200);
      wr(2'd0, 16'h5820);
      rd(2'd3, v);
      chk("R8 loopback allows rx", v, 16'h9600);
      chk("R8 rx_en with loop", {14'd0, tx_en, rx_en}, 16'h0003);
      wr(2'd0, 16'h4020);
      rd(2'd3, v);
      chk("R8 no rx enable", v, 16'h9000);
   endtask

   task automatic t_error;
      logic [15:0] v;
      wr(2'd3, 16'h0000);
      wr(2'd0, 16'h0030);
      wr(2'd3, 16'h8000);
      rd(2'd3, v);
      chk("R9 two modes error", v, 16'hC000);
      chk("R9 no mode outputs", {13'd0, mode_sir, mode_mir, mode_fir}, 16'h0000);
      wr(2'd3, 16'h0000);
      rd(2'd3, v);
      chk("R9 error holds when disabled", v, 16'h4000);
      wr(2'd0, 16'h0000);
      wr(2'd3, 16'h8000);
      rd(2'd3, v);
      chk("R9 zero modes error", v, 16'hC000);
      wr(2'd3, 16'h0000);
      wr(2'd0, 16'h0040);
      wr(2'd3, 16'h8000);
      rd(2'd3, v);
      chk("R9 error cleared, fast on", v, 16'hA000);
      chk("R10 fast output", {13'd0, mode_sir, mode_mir, mode_fir, cfg_err}, 16'h0002);
   endtask

   task automatic t_live;
      wr(2'd0, 16'h460F);
      chk("R11 live outputs",
          {9'd0, loop_en, master_en, rx_any, sir_filt, sir_filt_test, tx_invert, rx_invert},
          16'h007F);
      wr(2'd0, 16'h0000);
      chk("R11 live outputs cleared",
          {9'd0, loop_en, master_en, rx_any, sir_filt, sir_filt_test, tx_invert, rx_invert},
          16'h0000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cfg_rw();
      t_shadow_commit();
      t_cphy_ro();
      t_disable_recommit();
      t_txrx();
      t_error();
      t_live();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule